// File: doc/BRIEF.md
# Three-Slot Decode Steering with Micro-op Lamination

This block sits between an instruction pre-decode queue and a three-wide decoder. Every cycle it looks at up to three pre-decoded instruction descriptors, oldest first. Each descriptor carries a valid bit, a raw micro-op count, a flag marking a 128-bit vector operation whose 64-bit halves may be merged, an opcode tag and a sequence number. The block decides how many of those instructions enter the decoders in this cycle. It tells the queue how many it consumed and registers one micro-op descriptor per filled slot.

The decode slots are not equal. Slot 0 accepts an instruction of any size. Slots 1 and 2 accept only instructions that produce a single micro-op. When lamination is enabled, a vector operation's pairs of 64-bit micro-ops are folded into laminated micro-ops. This halves its count, so a two-micro-op vector instruction becomes a single laminated micro-op and may use any slot. A lamination-enable input makes it possible to compare decode throughput with folding on and off.

The registered slot assignment is offered downstream with a valid/ready handshake and is held while downstream stalls.

Top module: `dc_steer`

## Requirements
- R1: After reset, `out_valid` and all bits of `out_slot_vld` are 0. With no valid input, `in_take` is 0.
- R2: Slot 0 accepts the oldest valid instruction whatever its effective micro-op count. It reports that count in `out_nuop` slot 0, which is bits [2:0].
- R3: Slots 1 and 2 accept an instruction only if its effective micro-op count is 1. Steering stops at the first instruction that does not fit, and nothing younger is taken in that cycle.
- R4: Consumption is strictly in order. An invalid descriptor at position k stops steering at k, even if younger descriptors are valid.
- R5: When `lam_en`=1, a descriptor with `in_vec`=1 and a raw count u≥2 is laminated: its effective count is ceil(u/2) and its `out_lam` bit is 1. Three two-micro-op vector instructions are therefore all taken in one cycle.
- R6: When `lam_en`=0, the effective count equals the raw count and `out_lam` is 0. At most one multi-micro-op vector instruction is taken per cycle.
- R7: While `out_valid`=1 and `out_ready`=0, `in_take` is 0 and all outputs keep their values.
- R8: Each filled output slot k carries the tag and sequence number of input descriptor k. Slot k occupies bits [4k+3:4k] of the tag bus and bits [6k+5:6k] of the sequence bus.
- R9: When the output register loads, `in_take` equals n, the number of slots filled in that cycle. On the next cycle `out_slot_vld` equals the n low bits set, and `out_valid` = (n>0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lam_en | input | 1 | Enables folding of 64-bit micro-op pairs |
| in_vld | input | 3 | Descriptor valid, bit 0 oldest |
| in_uops | input | 9 | Raw micro-op count, 3 bits per descriptor |
| in_vec | input | 3 | Descriptor is a foldable 128-bit vector operation |
| in_tag | input | 12 | Opcode tag, 4 bits per descriptor |
| in_seq | input | 18 | Sequence number, 6 bits per descriptor |
| in_take | output | 2 | Number of descriptors consumed this cycle |
| out_valid | output | 1 | Slot assignment available |
| out_ready | input | 1 | Downstream accepts the assignment |
| out_slot_vld | output | 3 | Per-slot filled flag |
| out_lam | output | 3 | Per-slot laminated flag |
| out_nuop | output | 9 | Per-slot effective micro-op count |
| out_tag | output | 12 | Per-slot opcode tag |
| out_seq | output | 18 | Per-slot sequence number |

## Verification
`in_take` is combinational and is due in the same cycle as the descriptors it answers. The bench therefore samples it one nanosecond after driving the inputs on the falling edge, before the next rising edge. Slot outputs pass through one register and are due after the next rising edge. The bench samples them on the falling edge that follows. During stalls, outputs are sampled on several consecutive falling edges and compared with the values captured before the stall.

// File: rtl/dc_steer_pkg.sv
// Package: shared definitions for the decode steering block.
// Assumes: slot 0 is the only slot that accepts multi-micro-op instructions.
package dc_steer_pkg;

    // Role a decode slot plays in the steering decision.
    typedef enum logic [0:0] {
        SLOT_LEAD = 1'b0,   // accepts any micro-op count
        SLOT_TAIL = 1'b1    // accepts single micro-op instructions only
    } slot_role_e;

    // Role of slot index k.
    function automatic slot_role_e role_of(input int k);
        return (k == 0) ? SLOT_LEAD : SLOT_TAIL;
    endfunction

endpackage

// File: rtl/dc_uop_count.sv
// Module: dc_uop_count
// Computes the effective micro-op count of one descriptor after optional
// lamination of 64-bit micro-op pairs. Assumes the raw count is nonzero
// for valid descriptors; a count of zero is treated as single.
module dc_uop_count #(
    parameter int UOPW = 3
) (
    input  logic [UOPW-1:0] raw_uops,
    input  logic            is_vec,
    input  logic            lam_en,
    output logic [UOPW-1:0] eff_uops,
    output logic            lam,
    output logic            single
);
    localparam int WIDE = UOPW + 1;

    logic [WIDE-1:0] rounded;

    // Fold pairs: a vector op with two or more micro-ops becomes ceil(u/2).
    always_comb begin
        rounded  = {1'b0, raw_uops} + WIDE'(1);
        lam      = is_vec && lam_en && (raw_uops >= UOPW'(2));
        eff_uops = lam ? rounded[UOPW:1] : raw_uops;
        single   = (eff_uops <= UOPW'(1));
    end

endmodule

// File: rtl/dc_slot_select.sv
// Module: dc_slot_select
// Decides which descriptors enter the decode slots this cycle. Slot 0
// takes the oldest valid descriptor; tail slots take a descriptor only if
// every older one was taken and it is single micro-op. Assumes bit 0 of
// each vector is the oldest descriptor.
module dc_slot_select
    import dc_steer_pkg::*;
#(
    parameter int SLOTS = 3,
    parameter int CNTW  = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] vld,
    input  logic [SLOTS-1:0] single,
    output logic [SLOTS-1:0] take,
    output logic [CNTW-1:0]  count
);
    genvar k;
    generate
        for (k = 0; k < SLOTS; k++) begin : g_slot
            if (role_of(k) == SLOT_LEAD) begin : g_lead
                // Lead slot: any valid descriptor fits.
                always_comb take[k] = vld[k];
            end else begin : g_tail
                // Tail slot: in-order chain plus single micro-op limit.
                always_comb take[k] = take[k-1] && vld[k] && single[k];
            end
        end
    endgenerate

    // Population of the prefix mask is the number consumed.
    always_comb begin
        count = '0;
        for (int i = 0; i < SLOTS; i++) begin
            count = count + CNTW'(take[i]);
        end
    end

endmodule

// File: rtl/dc_out_reg.sv
// Module: dc_out_reg
// Holds the per-slot micro-op descriptors for downstream with a
// valid/ready handshake. Loads when empty or when downstream accepts;
// otherwise keeps its contents. Assumes take is a prefix mask.
module dc_out_reg #(
    parameter int SLOTS = 3,
    parameter int UOPW  = 3,
    parameter int TAGW  = 4,
    parameter int SEQW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOTS-1:0]  take,
    input  logic [SLOTS-1:0]  lam,
    input  logic [SLOTS*UOPW-1:0] nuop,
    input  logic [SLOTS*TAGW-1:0] tag,
    input  logic [SLOTS*SEQW-1:0] seq,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [SLOTS-1:0]  out_slot_vld,
    output logic [SLOTS-1:0]  out_lam,
    output logic [SLOTS*UOPW-1:0] out_nuop,
    output logic [SLOTS*TAGW-1:0] out_tag,
    output logic [SLOTS*SEQW-1:0] out_seq
);
    // Valid and slot flags: cleared on reset, refreshed on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_slot_vld <= '0;
        end else if (load) begin
            out_valid    <= |take;
            out_slot_vld <= take;
        end
    end

    genvar k;
    generate
        for (k = 0; k < SLOTS; k++) begin : g_slot
            // Payload of slot k: captured on load, zeroed when slot unused.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_lam[k]                  <= 1'b0;
                    out_nuop[k*UOPW +: UOPW]    <= '0;
                    out_tag[k*TAGW +: TAGW]     <= '0;
                    out_seq[k*SEQW +: SEQW]     <= '0;
                end else if (load) begin
                    out_lam[k]                  <= take[k] & lam[k];
                    out_nuop[k*UOPW +: UOPW]    <= take[k] ? nuop[k*UOPW +: UOPW] : '0;
                    out_tag[k*TAGW +: TAGW]     <= take[k] ? tag[k*TAGW +: TAGW] : '0;
                    out_seq[k*SEQW +: SEQW]     <= take[k] ? seq[k*SEQW +: SEQW] : '0;
                end
            end

            if (k > 0) begin : g_tail_chk
                // Tail slots never hold a multi-micro-op instruction.
                p_tail_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    out_slot_vld[k] |-> (out_nuop[k*UOPW +: UOPW] == UOPW'(1)));
                // Filled slots form a prefix: slot k implies slot k-1.
                p_prefix_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    out_slot_vld[k] |-> out_slot_vld[k-1]);
            end
        end
    endgenerate

    // A stalled assignment stays in place until accepted.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_vld) &&
        $stable(out_lam) && $stable(out_nuop) && $stable(out_tag) && $stable(out_seq)));

    // An offered assignment always uses the lead slot.
    p_lead_used_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_slot_vld[0]);

endmodule

// File: rtl/dc_steer.sv
// Module: dc_steer (top)
// Steering stage of a three-wide decoder with micro-op lamination.
// Computes effective micro-op counts per descriptor, selects an in-order
// prefix that fits the asymmetric slots, reports the consumed count and
// registers the slot assignment behind a valid/ready handshake.
// Assumes the source removes exactly in_take descriptors each cycle.
module dc_steer #(
    parameter int SLOTS = 3,
    parameter int UOPW  = 3,
    parameter int TAGW  = 4,
    parameter int SEQW  = 6,
    localparam int CNTW = $clog2(SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lam_en,
    input  logic [SLOTS-1:0]      in_vld,
    input  logic [SLOTS*UOPW-1:0] in_uops,
    input  logic [SLOTS-1:0]      in_vec,
    input  logic [SLOTS*TAGW-1:0] in_tag,
    input  logic [SLOTS*SEQW-1:0] in_seq,
    output logic [CNTW-1:0]       in_take,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [SLOTS-1:0]      out_slot_vld,
    output logic [SLOTS-1:0]      out_lam,
    output logic [SLOTS*UOPW-1:0] out_nuop,
    output logic [SLOTS*TAGW-1:0] out_tag,
    output logic [SLOTS*SEQW-1:0] out_seq
);
    logic [SLOTS*UOPW-1:0] eff_uops;
    logic [SLOTS-1:0]      lam;
    logic [SLOTS-1:0]      single;
    logic [SLOTS-1:0]      take;
    logic [CNTW-1:0]       count;
    logic                  load;

    genvar k;
    generate
        for (k = 0; k < SLOTS; k++) begin : g_cnt
            dc_uop_count #(.UOPW(UOPW)) u_cnt (
                .raw_uops (in_uops[k*UOPW +: UOPW]),
                .is_vec   (in_vec[k]),
                .lam_en   (lam_en),
                .eff_uops (eff_uops[k*UOPW +: UOPW]),
                .lam      (lam[k]),
                .single   (single[k])
            );
        end
    endgenerate

    dc_slot_select #(.SLOTS(SLOTS), .CNTW(CNTW)) u_sel (
        .vld    (in_vld),
        .single (single),
        .take   (take),
        .count  (count)
    );

    // Register may load when empty or when downstream takes its contents.
    always_comb begin
        load    = !out_valid || out_ready;
        in_take = load ? count : '0;
    end

    dc_out_reg #(.SLOTS(SLOTS), .UOPW(UOPW), .TAGW(TAGW), .SEQW(SEQW)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .take         (take),
        .lam          (lam),
        .nuop         (eff_uops),
        .tag          (in_tag),
        .seq          (in_seq),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_slot_vld (out_slot_vld),
        .out_lam      (out_lam),
        .out_nuop     (out_nuop),
        .out_tag      (out_tag),
        .out_seq      (out_seq)
    );

    // Nothing is consumed while the held assignment is refused.
    p_no_take_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (in_take == '0));

    // Any consumption shows up as an offered assignment next cycle.
    p_take_offered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take != '0) |=> out_valid);

    // Folding is only reported when enabled on the cycle of the load.
    p_lam_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !lam_en) |=> (out_lam == '0));

endmodule

// File: tb/sim_dc_steer.sv
`timescale 1ns/1ps
module sim_dc_steer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lam_en;
    logic [2:0]  in_vld;
    logic [8:0]  in_uops;
    logic [2:0]  in_vec;
    logic [11:0] in_tag;
    logic [17:0] in_seq;
    logic [1:0]  in_take;
    logic        out_valid;
    logic        out_ready;
    logic [2:0]  out_slot_vld;
    logic [2:0]  out_lam;
    logic [8:0]  out_nuop;
    logic [11:0] out_tag;
    logic [17:0] out_seq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dc_steer u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected model: effective count and fold flag of one descriptor.
    function automatic int eff_of(input int u, input bit v, input bit le);
        return (v && le && u >= 2) ? (u + 1) / 2 : u;
    endfunction

    // Expected number taken for the current inputs.
    function automatic int exp_take(input bit le);
        int n = 0;
        for (int i = 0; i < 3; i++) begin
            if (!in_vld[i]) break;
            if (i > 0 && eff_of(int'(in_uops[i*3 +: 3]), in_vec[i], le) > 1) break;
            n++;
        end
        return n;
    endfunction

    // Compare registered slots against the expected prefix of n descriptors.
    task automatic check_slots(input int n, input bit le, input string req);
        check(out_valid == (n > 0), "R9 out_valid", int'(out_valid), int'(n > 0));
        for (int k = 0; k < 3; k++) begin
            check(out_slot_vld[k] == (k < n), "R9 slot vld", int'(out_slot_vld[k]), int'(k < n));
            if (k < n) begin
                int u = int'(in_uops[k*3 +: 3]);
                bit el = in_vec[k] && le && u >= 2;
                check(out_nuop[k*3 +: 3] == 3'(eff_of(u, in_vec[k], le)),
                      (k == 0) ? "R2 nuop" : req, int'(out_nuop[k*3 +: 3]), eff_of(u, in_vec[k], le));
                check(out_lam[k] == el, le ? "R5 lam" : "R6 lam", int'(out_lam[k]), int'(el));
                check(out_tag[k*4 +: 4] == in_tag[k*4 +: 4], "R8 tag",
                      int'(out_tag[k*4 +: 4]), int'(in_tag[k*4 +: 4]));
                check(out_seq[k*6 +: 6] == in_seq[k*6 +: 6], "R8 seq",
                      int'(out_seq[k*6 +: 6]), int'(in_seq[k*6 +: 6]));
            end
        end
    endtask

    // Drive one input set at a falling edge, check take and next-cycle slots.
    task automatic step(input logic [2:0] v, input logic [8:0] u, input logic [2:0] vec,
                        input bit le, input string req);
        int n;
        @(negedge clk);
        lam_en = le; in_vld = v; in_uops = u; in_vec = vec; out_ready = 1'b1;
        in_tag = {4'(u[2:0] + 3), 4'(u[5:3] + 7), 4'(u[8:6] + 11)} ^ {9'b0, vec};
        in_seq = {6'(checks + 2), 6'(checks + 1), 6'(checks)};
        #1;
        n = exp_take(le);
        check(int'(in_take) == n, req, int'(in_take), n);
        @(negedge clk);
        check_slots(n, le, req);
    endtask

    initial begin
        logic [11:0] h_tag; logic [17:0] h_seq; logic [8:0] h_nuop; logic [2:0] h_vld;
        rst_n = 1'b0; lam_en = 1'b0; in_vld = '0; in_uops = '0; in_vec = '0;
        in_tag = '0; in_seq = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(out_slot_vld == 3'b000, "R1 slot vld", int'(out_slot_vld), 0);
        check(in_take == 2'd0, "R1 take", int'(in_take), 0);

        // Throughput contrast: three two-micro-op vector instructions.
        step(3'b111, {3'd2, 3'd2, 3'd2}, 3'b111, 1'b1, "R5 three laminated");
        check(in_take == 2'd3, "R5 take three", int'(in_take), 3);
        step(3'b111, {3'd2, 3'd2, 3'd2}, 3'b111, 1'b0, "R6 one vector");
        check(in_take == 2'd1, "R6 take one", int'(in_take), 1);
        // Gap in validity stops steering.
        step(3'b101, {3'd1, 3'd1, 3'd1}, 3'b000, 1'b1, "R4 gap");
        // Four-micro-op vector folds to two: lead only.
        step(3'b111, {3'd1, 3'd4, 3'd1}, 3'b010, 1'b1, "R3 folded pair in tail");

        // Sweep: every count/vector combination, prefix lengths and a gap.
        for (int le = 0; le < 2; le++) begin
            for (int code = 0; code < 512; code++) begin
                for (int vp = 0; vp < 4; vp++) begin
                    logic [2:0] v = (vp == 0) ? 3'b001 : (vp == 1) ? 3'b011 :
                                    (vp == 2) ? 3'b111 : 3'b101;
                    logic [8:0] u;
                    logic [2:0] vec;
                    for (int i = 0; i < 3; i++) begin
                        u[i*3 +: 3] = 3'(((code >> (i*3)) & 3) + 1);
                        vec[i]      = code[i*3 + 2];
                    end
                    step(v, u, vec, le[0], (vp == 3) ? "R4 order" : "R3 steer");
                end
            end
        end

        // Stall: load an assignment, refuse it, change inputs.
        step(3'b111, {3'd1, 3'd1, 3'd3}, 3'b000, 1'b0, "R2 lead multi");
        h_tag = out_tag; h_seq = out_seq; h_nuop = out_nuop; h_vld = out_slot_vld;
        out_ready = 1'b0;
        in_vld = 3'b111; in_uops = {3'd1, 3'd1, 3'd1}; in_vec = 3'b000; in_tag = 12'hABC;
        for (int c = 0; c < 4; c++) begin
            #1;
            check(in_take == 2'd0, "R7 take", int'(in_take), 0);
            @(negedge clk);
            check(out_valid == 1'b1, "R7 valid", int'(out_valid), 1);
            check(out_slot_vld == h_vld && out_nuop == h_nuop, "R7 slots",
                  int'(out_slot_vld), int'(h_vld));
            check(out_tag == h_tag && out_seq == h_seq, "R7 payload", int'(out_tag), int'(h_tag));
        end
        out_ready = 1'b1;
        #1;
        check(in_take == 2'd3, "R7 release", int'(in_take), 3);
        @(negedge clk);
        check(out_tag == 12'hABC, "R8 after stall", int'(out_tag), 12'hABC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule